// File: doc/BRIEF.md
# Gate Driver Input Conditioner with Standby Sequencer

This block sits on the control side of an isolated gate driver. It receives a non-inverting drive input and an inverting drive input, both asynchronous to the local free-running clock. Each input passes through a two-flop synchronizer and then a per-input glitch filter. The two filtered levels are decoded into one drive command. That decode includes an interlock, so an inconsistent input pair can only ever turn the output off.

The same input pair also carries the power-saving protocol; no extra pin is used. Holding both inputs high for a long time puts the block into standby. Standby is left only through a timed pattern:
- a clean interval with the inputs not both high,
- then a both-high pulse whose length lies strictly inside a window,
- then a wake-up delay before the output may switch again.

Two flags go to the protection controller. `standby_o` reports the low-power state. `force_safe_o` tells the controller to hold the gate in the actively-low safe state.

Every duration is a parameter counted in clock cycles:

| Parameter | Meaning |
|---|---|
| `GLITCH_CYC` | glitch filter length |
| `FILT_CYC` | exit filter |
| `WUP_CYC` | lower bound of the exit window |
| `STBY_CYC` | standby entry time and upper bound of the exit window |
| `AWAKE_CYC` | wake-up delay |

The filter length is meant to stay well below the smallest output pulse the driver must pass.

Top module: `drv_input_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `drive_on_o`, `standby_o` and `force_safe_o` are all 0.
- R2: Outside the safe state, `drive_on_o` is 1 only when the filtered non-inverting input is 1 and the filtered inverting input is 0. The input pairs (0,0), (0,1) and (1,1) command off.
- R3: A new input level is accepted only after the synchronized input has differed from the accepted level for `GLITCH_CYC` consecutive cycles. It takes effect `2+GLITCH_CYC` clock edges after the pin changes. A pulse shorter than `GLITCH_CYC` cycles never changes any output.
- R4: A filtered both-high interval shorter than `STBY_CYC` cycles acts as a plain off command and leaves `standby_o` at 0.
- R5: When the filtered inputs stay both high for `STBY_CYC` consecutive cycles, `standby_o` and `force_safe_o` become 1 and `drive_on_o` becomes 0.
- R6: In standby, input changes that do not complete the exit sequence keep `standby_o` at 1 and `drive_on_o` at 0.
- R7: Exit needs two steps. First, the filtered inputs hold a non-both-high pair for at least `FILT_CYC` consecutive cycles. Then they are both high for L cycles with `WUP_CYC` < L < `STBY_CYC`, and the exit is recognised when that interval ends. A both-high interval that comes before the filter count is reached does not arm the exit.
- R8: An exit both-high interval with L ≤ `WUP_CYC`, or one that reaches `STBY_CYC` cycles, leaves the block in standby.
- R9: After a failed exit attempt, a fresh non-both-high interval of `FILT_CYC` cycles re-arms the exit, so a later valid window still wakes the block.
- R10: On a valid exit, `standby_o` falls while `force_safe_o` stays 1 for exactly `AWAKE_CYC` further cycles. After that, `drive_on_o` again follows R2.
- R11: `force_safe_o` is 1 whenever `standby_o` is 1, and `drive_on_o` is 0 whenever `force_safe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_pos_i | input | 1 | Non-inverting drive input, asynchronous |
| in_neg_i | input | 1 | Inverting drive input, asynchronous |
| drive_on_o | output | 1 | Drive command: 1 turns the gate on |
| standby_o | output | 1 | Block is in the low-power standby state |
| force_safe_o | output | 1 | Protection controller must hold the gate safely low |

## Verification
The assertions check relations that hold on every cycle:
- the nesting of the two flags and the blocking of the drive command (R11);
- a filtered level only ever changing to the value the synchronizer held on the cycle before (R3);
- standby only beginning after a both-high sample (R5);
- the wake-up interval never running longer than `AWAKE_CYC` cycles (R10).

Other behaviour depends on how long an input pattern lasts, and only the bench's scenarios can show it. This covers:
- exit windows one cycle either side of the bounds;
- a filter interval one cycle short;
- a both-high pulse that runs too long;
- a retry after a failed attempt.

The bench's cycle model checks each of these.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_WAIT_FILT = 3'd1,
    ST_ARMED     = 3'd2,
    ST_WINDOW    = 3'd3,
    ST_WAKE      = 3'd4
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Width needed to hold values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Exit window is open on both sides: lo < len < hi.
  function automatic logic window_ok(input int len, input int lo, input int hi);
    return (len > lo) && (len < hi);
  endfunction

endpackage

// File: rtl/drv_sync2.sv
module drv_sync2 #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/drv_deglitch.sv
module drv_deglitch #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  import drv_seq_pkg::*;

  localparam int CW = cnt_width(GLITCH_CYC);
  localparam logic [CW-1:0] LIM = CW'(GLITCH_CYC - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LIM) begin
      lvl_q <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/drv_stby_seq.sv
module drv_stby_seq #(
  parameter int FILT_CYC  = 28,
  parameter int WUP_CYC   = 2000,
  parameter int STBY_CYC  = 28000,
  parameter int AWAKE_CYC = 14000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic both_hi_i,
  output logic standby_o,
  output logic safe_o,
  output logic ev_enter_o,
  output logic ev_wake_o,
  output logic ev_fail_o
);
  import drv_seq_pkg::*;

  localparam int RW = cnt_width(max_of(max_of(STBY_CYC, AWAKE_CYC), FILT_CYC));
  localparam logic [RW-1:0] STBY_LAST  = RW'(STBY_CYC - 1);
  localparam logic [RW-1:0] FILT_LAST  = RW'(FILT_CYC - 1);
  localparam logic [RW-1:0] AWAKE_LAST = RW'(AWAKE_CYC - 1);

  seq_state_e    state_q, state_n;
  logic [RW-1:0] run_q, run_n;

  always_comb begin
    state_n    = state_q;
    run_n      = run_q;
    ev_enter_o = 1'b0;
    ev_wake_o  = 1'b0;
    ev_fail_o  = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (!both_hi_i) run_n = '0;
        else if (run_q == STBY_LAST) begin
          state_n    = ST_WAIT_FILT;
          run_n      = '0;
          ev_enter_o = 1'b1;
        end else run_n = run_q + 1'b1;
      end
      ST_WAIT_FILT: begin
        if (both_hi_i) run_n = '0;
        else if (run_q == FILT_LAST) begin
          state_n = ST_ARMED;
          run_n   = '0;
        end else run_n = run_q + 1'b1;
      end
      ST_ARMED: begin
        if (both_hi_i) begin
          state_n = ST_WINDOW;
          run_n   = RW'(1);
        end
      end
      ST_WINDOW: begin
        if (both_hi_i) begin
          if (run_q == STBY_LAST) begin
            state_n   = ST_WAIT_FILT;
            run_n     = '0;
            ev_fail_o = 1'b1;
          end else run_n = run_q + 1'b1;
        end else if (window_ok(int'(run_q), WUP_CYC, STBY_CYC)) begin
          state_n   = ST_WAKE;
          run_n     = '0;
          ev_wake_o = 1'b1;
        end else begin
          state_n   = ST_WAIT_FILT;
          run_n     = RW'(1);
          ev_fail_o = 1'b1;
        end
      end
      ST_WAKE: begin
        if (run_q == AWAKE_LAST) begin
          state_n = ST_ACTIVE;
          run_n   = '0;
        end else run_n = run_q + 1'b1;
      end
      default: begin
        state_n = ST_ACTIVE;
        run_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACTIVE;
      run_q   <= '0;
    end else begin
      state_q <= state_n;
      run_q   <= run_n;
    end
  end

  assign standby_o = (state_q == ST_WAIT_FILT) || (state_q == ST_ARMED) ||
                     (state_q == ST_WINDOW);
  assign safe_o    = (state_q != ST_ACTIVE);
endmodule

// File: rtl/drv_input_seq.sv
module drv_input_seq #(
  parameter int GLITCH_CYC = 4,
  parameter int FILT_CYC   = 28,
  parameter int WUP_CYC    = 2000,
  parameter int STBY_CYC   = 28000,
  parameter int AWAKE_CYC  = 14000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_pos_i,
  input  logic in_neg_i,
  output logic drive_on_o,
  output logic standby_o,
  output logic force_safe_o
);
  localparam int NIN = 2;

  logic [NIN-1:0] raw_in, sync_in, filt_in;
  logic sync_pos, sync_neg, filt_pos, filt_neg, both_hi;
  logic ev_enter, ev_wake, ev_fail;

  assign raw_in = {in_neg_i, in_pos_i};

  drv_sync2 #(.W(NIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  for (genvar g = 0; g < NIN; g++) begin : g_flt
    drv_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sync_in[g]),
      .q_o   (filt_in[g])
    );
  end

  assign sync_pos = sync_in[0];
  assign sync_neg = sync_in[1];
  assign filt_pos = filt_in[0];
  assign filt_neg = filt_in[1];
  assign both_hi  = filt_pos & filt_neg;

  drv_stby_seq #(
    .FILT_CYC (FILT_CYC),
    .WUP_CYC  (WUP_CYC),
    .STBY_CYC (STBY_CYC),
    .AWAKE_CYC(AWAKE_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .both_hi_i (both_hi),
    .standby_o (standby_o),
    .safe_o    (force_safe_o),
    .ev_enter_o(ev_enter),
    .ev_wake_o (ev_wake),
    .ev_fail_o (ev_fail)
  );

  // Interlock: only the (1,0) pair turns the gate on.
  assign drive_on_o = !force_safe_o && filt_pos && !filt_neg;
endmodule

// File: rtl/drv_input_seq_chk.sv
module drv_input_seq_chk #(
  parameter int AWAKE_CYC = 14000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sync_pos,
  input logic sync_neg,
  input logic filt_pos,
  input logic filt_neg,
  input logic ev_wake,
  input logic drive_on_o,
  input logic standby_o,
  input logic force_safe_o
);
  int wake_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_run <= 0;
    else if (force_safe_o && !standby_o) wake_run <= wake_run + 1;
    else wake_run <= 0;
  end

  AST_SAFE_COVERS_STBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> force_safe_o); // R11
  AST_SAFE_BLOCKS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_safe_o |-> !drive_on_o); // R11
  AST_POS_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_pos) |-> (filt_pos == $past(sync_pos))); // R3
  AST_NEG_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_neg) |-> (filt_neg == $past(sync_neg))); // R3
  AST_ENTRY_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> $past(filt_pos && filt_neg)); // R5
  AST_WAKE_KEEPS_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(standby_o) |-> force_safe_o); // R10
  AST_WAKE_FROM_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wake |=> (!standby_o && force_safe_o)); // R7
  AST_WAKE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_run <= AWAKE_CYC); // R10
endmodule

bind drv_input_seq drv_input_seq_chk #(.AWAKE_CYC(AWAKE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_pos    (sync_pos),
  .sync_neg    (sync_neg),
  .filt_pos    (filt_pos),
  .filt_neg    (filt_neg),
  .ev_wake     (ev_wake),
  .drive_on_o  (drive_on_o),
  .standby_o   (standby_o),
  .force_safe_o(force_safe_o)
);

// File: tb/drv_input_seq_tb.sv
module drv_input_seq_tb;
  localparam int G = 3, F = 5, W = 15, S = 60, A = 30;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, nin = 1'b0;
  logic drive, stby, safe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  drv_input_seq #(.GLITCH_CYC(G), .FILT_CYC(F), .WUP_CYC(W), .STBY_CYC(S),
                  .AWAKE_CYC(A)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_pos_i(pin), .in_neg_i(nin),
    .drive_on_o(drive), .standby_o(stby), .force_safe_o(safe));

  // Behavioural reference: integer state, 0=active 1..3=standby phases 4=waking
  int p1, p2, n1, n2, fp, fn, cp, cn, st, run;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; n1 = 0; n2 = 0; fp = 0; fn = 0; cp = 0; cn = 0; st = 0; run = 0;
    end else begin
      bit both;
      both = (fp == 1) && (fn == 1);
      case (st)
        0: if (both) begin run++; if (run == S) begin st = 1; run = 0; end end
           else run = 0;
        1: if (!both) begin run++; if (run == F) begin st = 2; run = 0; end end
           else run = 0;
        2: if (both) begin st = 3; run = 1; end
        3: if (both) begin run++; if (run == S) begin st = 1; run = 0; end end
           else if (run > W) begin st = 4; run = 0; end
           else begin st = 1; run = 1; end
        default: begin run++; if (run == A) begin st = 0; run = 0; end end
      endcase
      if (p2 == fp) cp = 0; else begin cp++; if (cp == G) begin fp = p2; cp = 0; end end
      if (n2 == fn) cn = 0; else begin cn++; if (cn == G) begin fn = n2; cn = 0; end end
      p2 = p1; p1 = int'(pin);
      n2 = n1; n1 = int'(nin);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2", "drive_on_o", int'(drive), int'(st == 0 && fp == 1 && fn == 0));
    chk("R5", "standby_o", int'(stby), int'(st >= 1 && st <= 3));
    chk("R10", "force_safe_o", int'(safe), int'(st != 0));
  end

  task automatic hold(input logic p, input logic n, input int cyc);
    pin = p; nin = n;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "drive in reset", int'(drive), 0);
    chk("R1", "standby in reset", int'(stby), 0);
    chk("R1", "safe in reset", int'(safe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "safe after reset", int'(safe), 0);

    hold(1, 0, 20);
    chk("R2", "on for (1,0)", int'(drive), 1);
    // short low glitch on pos, then check right after
    hold(0, 0, G - 1);
    hold(1, 0, 10);
    chk("R3", "glitch rejected", int'(drive), 1);
    hold(0, 0, G);
    hold(1, 0, 2 + G - 1);
    chk("R3", "accepted low after G", int'(drive), 0);
    hold(1, 0, 10);
    hold(1, 1, 50);
    chk("R4", "short both-high no standby", int'(stby), 0);
    chk("R2", "off for (1,1)", int'(drive), 0);
    hold(0, 1, 10);
    chk("R2", "off for (0,1)", int'(drive), 0);
    hold(0, 0, 10);
    chk("R2", "off for (0,0)", int'(drive), 0);

    hold(1, 1, 80);
    chk("R5", "standby entered", int'(stby), 1);
    chk("R11", "safe with standby", int'(safe), 1);
    hold(1, 0, 20);
    chk("R6", "standby held on (1,0)", int'(stby), 1);
    chk("R6", "drive blocked", int'(drive), 0);
    hold(1, 1, 80);
    hold(0, 0, 10);
    chk("R8", "too long window", int'(stby), 1);
    hold(1, 1, W);
    hold(0, 0, 4);
    chk("R8", "too short window", int'(stby), 1);
    hold(1, 1, W + 1);
    hold(0, 1, 10);
    chk("R7", "filter interval too short", int'(stby), 1);
    hold(1, 1, W + 1);
    hold(1, 0, 15);
    chk("R9", "retry wakes", int'(stby), 0);
    chk("R10", "safe during wake delay", int'(safe), 1);
    chk("R10", "drive blocked during wake", int'(drive), 0);
    hold(1, 0, 40);
    chk("R10", "safe released", int'(safe), 0);
    chk("R10", "drive follows inputs", int'(drive), 1);

    hold(1, 1, 80);
    hold(0, 0, 10);
    hold(1, 1, S - 1);
    hold(0, 1, 15);
    chk("R7", "upper bound window wakes", int'(stby), 0);
    hold(0, 0, 50);
    chk("R10", "active after second wake", int'(safe), 0);
    finish_run();
  end
endmodule